// File: doc/BRIEF.md
# Masked Byte Inversion with Log-Domain Mask Correction

This block inverts one byte in the field GF(2^8) while the byte stays hidden under a boolean mask. The caller supplies the masked byte (the secret byte XOR a random mask) and the mask itself. The block returns two things: the inverse of the masked byte, and a multiplicative correction. The correction relates that inverse to the inverse of the hidden byte. The secret byte is never formed on any wire.

All the work is done with discrete logarithms. A product becomes a sum of logarithms modulo 255, and an inverse becomes a negated logarithm. The correction is found as follows:
- The logarithm of the mask is subtracted from the logarithm of the masked byte, which yields the quotient of the masked byte by the mask.
- That quotient is XORed with one and inverted.
- The result is XORed with one again and inverted a second time.

An optional last stage changes the multiplicative mask back into a boolean one under a fresh random byte. The pipeline has three stages and a constant latency. It accepts a new operand every cycle. A new mask must be drawn for every run; that is the caller's job.

Top module: `masked_inv_top`

## Requirements
- R1: The field is GF(2^8) reduced by x^8+x^4+x^3+x+1, with generator 0x03. inv_masked equals the field inverse of masked_in, and zero maps to zero.
- R2: Let the hidden byte be A = masked_in XOR mask_r. When A is non-zero and differs from mask_r, correction equals the inverse of ((mask_r · A^-1) XOR 0x01), so that inv_masked = A^-1 · correction.
- R3: When the hidden byte A is zero (masked_in equals mask_r), correction is 0x01 and inv_masked is the inverse of mask_r.
- R4: When masked_in is zero (A equals mask_r), both inv_masked and correction are zero.
- R5: remasked equals A^-1 XOR mask_p for every input, with zero's inverse taken as zero. This covers both corner cases above.
- R6: valid is high exactly three clock edges after start is sampled, counting the sampling edge. It stays high for one cycle per start, and the latency does not depend on the data.
- R7: A start may be given every cycle. The results come out in the order of the starts.
- R8: After reset, valid is low and inv_masked, correction and remasked are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operands are valid this cycle |
| masked_in | input | 8 | Hidden byte XOR mask_r |
| mask_r | input | 8 | Boolean mask, non-zero |
| mask_p | input | 8 | Fresh mask for the remask stage |
| valid | output | 1 | Results valid this cycle |
| inv_masked | output | 8 | Inverse of masked_in |
| correction | output | 8 | Multiplicative mask correction |
| remasked | output | 8 | Hidden byte's inverse XOR mask_p (zero when the stage is disabled) |

## Verification
The bench covers three corners.
- Hidden byte zero. Here the log-domain quotient collapses to zero. A design that forgot the augmented log convention would return a garbage correction, or would remask the mask's inverse instead of returning mask_p.
- Masked byte zero. A design that wrapped the logarithm of zero into range would produce a non-zero inverse or correction.
- Back-to-back starts. A pipeline that stalled or reordered would shift results against their operands, and a bad valid alignment would show up as an early or late strobe.

// File: rtl/masked_inv_pkg.sv
package masked_inv_pkg;
    localparam int FW = 8;
    localparam logic [FW-1:0] POLY_LO = 8'h1B;
    localparam logic [FW-1:0] GEN_DEF = 8'h03;

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b,
                                          input logic [7:0] poly);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = '0;
        sh  = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? poly : 8'h00);
        end
        return acc;
    endfunction

    // Index of the inverse in log form; 255 stands for the zero element.
    function automatic logic [7:0] neg_log(input logic [7:0] lg);
        if (lg == 8'hFF)      return 8'hFF;
        else if (lg == 8'h00) return 8'h00;
        else                  return 8'hFF - lg;
    endfunction

    function automatic logic [7:0] add_log(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= 9'd255) s = s - 9'd255;
        return s[7:0];
    endfunction

    function automatic logic [7:0] sub_log(input logic [7:0] a, input logic [7:0] b);
        if (a >= b) return a - b;
        else        return a + (8'hFF - b);
    endfunction
endpackage

// File: rtl/masked_inv_log_lut.sv
module masked_inv_log_lut
    import masked_inv_pkg::*;
#(
    parameter logic [7:0] POLY = POLY_LO,
    parameter logic [7:0] GEN  = GEN_DEF
) (
    input  logic [7:0] elem_i,
    output logic [7:0] log_o
);
    always_comb begin
        logic [7:0] acc;
        acc   = 8'h01;
        log_o = 8'hFF;
        for (int k = 0; k < 255; k++) begin
            if (acc == elem_i && log_o == 8'hFF) log_o = 8'(k);
            acc = gf_mul(acc, GEN, POLY);
        end
    end
endmodule

// File: rtl/masked_inv_alog_lut.sv
module masked_inv_alog_lut
    import masked_inv_pkg::*;
#(
    parameter logic [7:0] POLY = POLY_LO,
    parameter logic [7:0] GEN  = GEN_DEF
) (
    input  logic [7:0] idx_i,
    input  logic [7:0] out_mask_i,
    output logic [7:0] elem_o
);
    always_comb begin
        logic [7:0] acc;
        logic [7:0] hit;
        acc = 8'h01;
        hit = 8'h00;
        for (int k = 0; k < 255; k++) begin
            if (idx_i == 8'(k)) hit = acc;
            acc = gf_mul(acc, GEN, POLY);
        end
        elem_o = hit ^ out_mask_i;
    end
endmodule

// File: rtl/masked_inv_top.sv
module masked_inv_top
    import masked_inv_pkg::*;
#(
    parameter logic [7:0] POLY      = POLY_LO,
    parameter logic [7:0] GEN       = GEN_DEF,
    parameter bit         REMASK_EN = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] masked_in,
    input  logic [7:0] mask_r,
    input  logic [7:0] mask_p,
    output logic       valid,
    output logic [7:0] inv_masked,
    output logic [7:0] correction,
    output logic [7:0] remasked
);
    typedef struct packed {
        logic       v1;
        logic [7:0] lm1;
        logic [7:0] lr1;
        logic [7:0] p1;
        logic       v2;
        logic [7:0] u2;
        logic [7:0] im2;
        logic [7:0] lr2;
        logic [7:0] p2;
        logic       mz2;
        logic       v3;
        logic [7:0] inv3;
        logic [7:0] cor3;
        logic [7:0] rem3;
        logic [7:0] p3;
    } pipe_t;

    pipe_t st_q, st_d;

    logic [7:0] lm_w, lr_w, t_w, im_w, lu_w, v_w, lw_w, c_w, rem_w;
    logic [7:0] e_idx, im_idx, w_val, rem_idx;

    // stage 1: logarithms of the masked byte and the mask
    masked_inv_log_lut #(.POLY(POLY), .GEN(GEN)) u_log_m (.elem_i(masked_in), .log_o(lm_w));
    masked_inv_log_lut #(.POLY(POLY), .GEN(GEN)) u_log_r (.elem_i(mask_r),    .log_o(lr_w));

    // stage 2: quotient masked/mask and plain inverse of the masked byte
    assign e_idx  = (st_q.lm1 == 8'hFF) ? 8'hFF : sub_log(st_q.lm1, st_q.lr1);
    assign im_idx = neg_log(st_q.lm1);
    masked_inv_alog_lut #(.POLY(POLY), .GEN(GEN)) u_alog_q (.idx_i(e_idx),  .out_mask_i(8'h00), .elem_o(t_w));
    masked_inv_alog_lut #(.POLY(POLY), .GEN(GEN)) u_alog_i (.idx_i(im_idx), .out_mask_i(8'h00), .elem_o(im_w));

    // stage 3: two inversions build the correction
    masked_inv_log_lut  #(.POLY(POLY), .GEN(GEN)) u_log_u  (.elem_i(st_q.u2), .log_o(lu_w));
    masked_inv_alog_lut #(.POLY(POLY), .GEN(GEN)) u_alog_v (.idx_i(neg_log(lu_w)), .out_mask_i(8'h00), .elem_o(v_w));
    assign w_val = v_w ^ 8'h01;
    masked_inv_log_lut  #(.POLY(POLY), .GEN(GEN)) u_log_w  (.elem_i(w_val), .log_o(lw_w));
    masked_inv_alog_lut #(.POLY(POLY), .GEN(GEN)) u_alog_c (.idx_i(neg_log(lw_w)), .out_mask_i(8'h00), .elem_o(c_w));

    generate
        if (REMASK_EN) begin : g_remask
            logic [7:0] lim_w;
            masked_inv_log_lut #(.POLY(POLY), .GEN(GEN)) u_log_im (.elem_i(st_q.im2), .log_o(lim_w));
            assign rem_idx = (st_q.u2 == 8'h00) ? 8'hFF :
                             st_q.mz2           ? neg_log(st_q.lr2) :
                                                  add_log(lim_w, lw_w);
            masked_inv_alog_lut #(.POLY(POLY), .GEN(GEN)) u_alog_rem (.idx_i(rem_idx), .out_mask_i(st_q.p2), .elem_o(rem_w));
        end else begin : g_noremask
            assign rem_idx = 8'hFF;
            assign rem_w   = 8'h00;
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.v1   = start;
        st_d.lm1  = lm_w;
        st_d.lr1  = lr_w;
        st_d.p1   = mask_p;
        st_d.v2   = st_q.v1;
        st_d.u2   = t_w ^ 8'h01;
        st_d.im2  = im_w;
        st_d.lr2  = st_q.lr1;
        st_d.p2   = st_q.p1;
        st_d.mz2  = (st_q.lm1 == 8'hFF);
        st_d.v3   = st_q.v2;
        st_d.inv3 = st_q.im2;
        st_d.cor3 = c_w;
        st_d.rem3 = rem_w;
        st_d.p3   = st_q.p2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid      = st_q.v3;
    assign inv_masked = st_q.inv3;
    assign correction = st_q.cor3;
    assign remasked   = st_q.rem3;

    // R6
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ##3 valid);
    // R2
    nonzero_cor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && correction != 8'h00) |-> inv_masked != 8'h00);
    // R4
    zero_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && inv_masked == 8'h00) |-> correction == 8'h00);
    // R5
    hidden_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && correction == 8'h01 && REMASK_EN) |-> remasked == st_q.p3);
    // R1
    mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> mask_r != 8'h00);
endmodule

// File: tb/masked_inv_top_tb_top.sv
module masked_inv_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] masked_in = '0, mask_r = 8'h01, mask_p = '0;
    logic       valid;
    logic [7:0] inv_masked, correction, remasked;
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    masked_inv_top dut_i (.clk(clk), .rst_n(rst_n), .start(start), .masked_in(masked_in),
        .mask_r(mask_r), .mask_p(mask_p), .valid(valid), .inv_masked(inv_masked),
        .correction(correction), .remasked(remasked));

    function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r, x;
        r = 0; x = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) r ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
        end
        return r;
    endfunction

    function automatic logic [7:0] binv(input logic [7:0] a);
        for (int y = 1; y < 256; y++) if (bmul(a, 8'(y)) == 8'h01) return 8'(y);
        return 8'h00;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // hidden byte A, mask R, fresh mask P
    localparam logic [23:0] VEC [10] = '{
        24'h53_CA_11, 24'h01_01_00, 24'h00_7E_5A, 24'h00_01_33, 24'hFF_80_C3,
        24'h7E_7E_A5, 24'h02_03_FF, 24'hAB_CD_EF, 24'h10_01_00, 24'h80_1B_44};

    task automatic check_result(input logic [7:0] a, input logic [7:0] r, input logic [7:0] p);
        logic [7:0] m, ecor;
        m = a ^ r;
        ecor = (a == 0) ? 8'h01 : binv(bmul(r, binv(a)) ^ 8'h01);
        chk("R6 valid", {7'd0, valid}, 8'h01);
        chk((m == 0) ? "R4 inv_masked" : (a == 0) ? "R3 inv_masked" : "R1 inv_masked",
            inv_masked, binv(m));
        chk((m == 0) ? "R4 correction" : (a == 0) ? "R3 correction" : "R2 correction",
            correction, ecor);
        chk("R5 remasked", remasked, binv(a) ^ p);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 valid", {7'd0, valid}, 8'h00);
        chk("R8 inv_masked", inv_masked, 8'h00);
        chk("R8 correction", correction, 8'h00);
        chk("R8 remasked", remasked, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            masked_in = VEC[i][23:16] ^ VEC[i][15:8];
            mask_r = VEC[i][15:8];
            mask_p = VEC[i][7:0];
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            chk("R6 early", {7'd0, valid}, 8'h00);
            @(negedge clk);
            check_result(VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
            @(negedge clk);
            chk("R6 single", {7'd0, valid}, 8'h00);
        end
        // R7 back-to-back starts
        for (int k = 0; k < 8; k++) begin
            if (k >= 3) check_result(VEC[k-3][23:16], VEC[k-3][15:8], VEC[k-3][7:0]);
            if (k < 5) begin
                masked_in = VEC[k][23:16] ^ VEC[k][15:8];
                mask_r = VEC[k][15:8];
                mask_p = VEC[k][7:0];
                start = 1'b1;
            end else start = 1'b0;
            @(negedge clk);
        end
        chk("R7 drain", {7'd0, valid}, 8'h00);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule